// File: doc/BRIEF.md
# YCbCr to RGB888 Colour Converter

This block is a streaming colour-space converter for a display scaling path. Each accepted input word carries one or two pixels. The word holds either a luma/chroma sample set (planar, or packed 4:2:2 in one of four byte orders) or an RGB pixel in a 15-, 16- or 24-bit layout. The block returns one saturated 8-bit-per-channel RGB pixel per output transfer.

Luma/chroma pixels are converted in stages. First the programmable luma offset is removed from Y, and the chroma offset from Cb and Cr. Five unsigned coefficients, each read as a fraction of 1024, then weight the results: red adds a Cr term to the luma term, blue adds a Cb term, and green subtracts both a Cb term and a Cr term. RGB input skips the arithmetic. It is widened to 8 bits per channel and can have red and blue exchanged.

Both sides use valid/ready handshakes. The datapath is a three-register pipeline that stalls as a whole when the output is not taken. The offset and coefficient inputs are static configuration and are changed only while the pipeline is empty. Typical values are luma offset 0, chroma offset 128, and coefficients 0x4A8, 0x662, 0x191, 0x341 and 0x811.

Top module: `ycc_rgb_conv`

## Requirements
- R1: Within a reset cycle (`rst_n` low at a rising edge), `out_valid` goes low. After reset is released, with no input offered, `in_ready` is high.
- R2: The converter computes y = Y - `luma_off`, u = Cb - `chroma_off` and v = Cr - `chroma_off` as signed values before weighting.
- R3: The channel sums are R = c0*y + c1*v, G = c0*y - c2*u - c3*v and B = c0*y + c4*u. Each sum is divided by 1024 with rounding toward minus infinity (arithmetic shift right by 10).
- R4: Every converted channel saturates to 0..255: a negative quotient gives 0 and a quotient above 255 gives 255.
- R5: `in_fmt` = 1 selects packed 4:2:2. The bytes are b0 = `in_data[7:0]` up to b3 = `in_data[31:24]`. `in_order` 0 means b0..b3 = Y0,Cb,Y1,Cr; 1 means Y0,Cr,Y1,Cb; 2 means Cb,Y0,Cr,Y1; 3 means Cr,Y0,Cb,Y1. The word yields a Y0 pixel and then a Y1 pixel that share the chroma. `in_ready` is low in the cycle after such a word is accepted.
- R6: `in_fmt` = 0 selects planar samples: Y = `in_data[7:0]`, Cb = `in_data[15:8]`, Cr = `in_data[23:16]`, one pixel per word.
- R7: `in_fmt` = 2 is RGB555: R `[14:10]`, G `[9:5]`, B `[4:0]`. `in_fmt` = 3 is RGB565: R `[15:11]`, G `[10:5]`, B `[4:0]`. Each field is widened to 8 bits by repeating its top bits into the low bits.
- R8: `in_fmt` = 4 to 7 pass RGB888 through unchanged: R `[23:16]`, G `[15:8]`, B `[7:0]`. For any RGB format, `in_swap` = 1 exchanges the R and B outputs. `in_swap` has no effect on luma/chroma formats.
- R9: When the pipeline is empty and `out_ready` stays high, a pixel accepted at one rising edge shows `out_valid` after the third rising edge, counting the accepting edge as the first.
- R10: While `out_valid` is high and `out_ready` is low, the output pixel holds stable and `in_ready` is low. Pixels leave in input order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken at this edge when valid |
| in_data | input | 32 | Input word, layout set by `in_fmt` |
| in_fmt | input | 3 | 0 planar, 1 packed 4:2:2, 2 RGB555, 3 RGB565, 4-7 RGB888 |
| in_order | input | 2 | Byte order for packed 4:2:2 |
| in_swap | input | 1 | Exchange R and B for RGB formats |
| luma_off | input | 8 | Value removed from Y |
| chroma_off | input | 8 | Value removed from Cb and Cr |
| coef_c0 | input | COEF_W | Luma weight, /1024 |
| coef_c1 | input | COEF_W | Cr weight into R, /1024 |
| coef_c2 | input | COEF_W | Cb weight subtracted from G, /1024 |
| coef_c3 | input | COEF_W | Cr weight subtracted from G, /1024 |
| coef_c4 | input | COEF_W | Cb weight into B, /1024 |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Output pixel taken at this edge when valid |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
The bench targets these corner cases:

- **Saturation at both ends.** Full-scale Y with full-scale Cr overflows red, and zero samples underflow it. A converter that wrapped instead of clamping would return bright colours as dark ones, or the reverse.
- **All four packed byte orders.** The bench sends bytes that are all distinct, so an order that swapped chroma with luma, or that gave the second pixel the wrong luma, shows up as a wrong colour in one pixel of the pair.
- **Irregular back-pressure over mixed formats.** If one stage kept advancing while the output was held, pixels would be lost or repeated. If the second half of a packed word were dropped during a stall, every later pixel would be compared one place off.
- **Swap control on luma/chroma input.** The bench sets the swap control with luma/chroma input to confirm that it leaves those pixels alone.

// File: rtl/ycc_pkg.sv
// Shared types and constants for the colour converter.
// Assumes 8-bit samples; coefficient width is a parameter of the modules.
package ycc_pkg;

    localparam int PIX_W  = 8;
    localparam int DIFF_W = PIX_W + 1;   // signed sample after offset removal
    localparam int WORD_W = 4 * PIX_W;   // one input word
    localparam int NPROD  = 5;           // weighted terms per pixel
    localparam int NCHAN  = 3;

    typedef enum logic [2:0] {
        FMT_PLANAR  = 3'd0,
        FMT_PACK422 = 3'd1,
        FMT_RGB555  = 3'd2,
        FMT_RGB565  = 3'd3,
        FMT_RGB888  = 3'd4
    } fmt_e;

    typedef struct packed {
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } rgb_t;

    // Operand feeding weighted term k: 0 = luma, 1 = Cb, 2 = Cr.
    function automatic int operand_of(input int k);
        case (k)
            0:       return 0;
            1, 3:    return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/ycc_front.sv
// Stage A: decodes the input word, splits packed 4:2:2 into two pixels,
// removes the offsets and expands RGB layouts.
// Assumes the offsets are stable while pixels are in flight.
module ycc_front
    import ycc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic                     in_valid,
    input  logic [WORD_W-1:0]        in_data,
    input  logic [2:0]               in_fmt,
    input  logic [1:0]               in_order,
    input  logic                     in_swap,
    input  logic [PIX_W-1:0]         luma_off,
    input  logic [PIX_W-1:0]         chroma_off,
    output logic                     in_ready,
    output logic                     a_valid,
    output logic                     a_yuv,
    output logic signed [DIFF_W-1:0] a_y,
    output logic signed [DIFF_W-1:0] a_u,
    output logic signed [DIFF_W-1:0] a_v,
    output rgb_t                     a_rgb
);

    logic [PIX_W-1:0] byt [4];
    logic [PIX_W-1:0] y0_w, y1_w, cb_w, cr_w;
    logic [PIX_W-1:0] pend_y, pend_cb, pend_cr;
    logic [PIX_W-1:0] sel_y, sel_cb, sel_cr;
    logic             pend_q, sel_yuv, is_yuv_in, is_pack;
    rgb_t             rgb_raw, rgb_w;

    for (genvar i = 0; i < 4; i++) begin : g_bytes
        assign byt[i] = in_data[PIX_W*i +: PIX_W];
    end

    function automatic logic signed [DIFF_W-1:0] sub_off(
        input logic [PIX_W-1:0] s, input logic [PIX_W-1:0] o);
        return $signed({1'b0, s}) - $signed({1'b0, o});
    endfunction

    assign is_pack   = (in_fmt == FMT_PACK422);
    assign is_yuv_in = (in_fmt == FMT_PLANAR) || is_pack;
    assign in_ready  = adv && !pend_q;

    // Pick luma and chroma bytes according to format and byte order.
    always_comb begin
        y0_w = byt[0];
        cb_w = byt[1];
        cr_w = byt[2];
        y1_w = byt[2];
        if (is_pack) begin
            case (in_order)
                2'd0: begin y0_w = byt[0]; cb_w = byt[1]; y1_w = byt[2]; cr_w = byt[3]; end
                2'd1: begin y0_w = byt[0]; cr_w = byt[1]; y1_w = byt[2]; cb_w = byt[3]; end
                2'd2: begin cb_w = byt[0]; y0_w = byt[1]; cr_w = byt[2]; y1_w = byt[3]; end
                default: begin cr_w = byt[0]; y0_w = byt[1]; cb_w = byt[2]; y1_w = byt[3]; end
            endcase
        end
    end

    // Widen RGB layouts to 8 bits per channel by repeating top bits.
    always_comb begin
        case (in_fmt)
            FMT_RGB555: begin
                rgb_raw.r = {in_data[14:10], in_data[14:12]};
                rgb_raw.g = {in_data[9:5],   in_data[9:7]};
                rgb_raw.b = {in_data[4:0],   in_data[4:2]};
            end
            FMT_RGB565: begin
                rgb_raw.r = {in_data[15:11], in_data[15:13]};
                rgb_raw.g = {in_data[10:5],  in_data[10:9]};
                rgb_raw.b = {in_data[4:0],   in_data[4:2]};
            end
            default: begin
                rgb_raw.r = in_data[23:16];
                rgb_raw.g = in_data[15:8];
                rgb_raw.b = in_data[7:0];
            end
        endcase
    end

    // Optional red/blue exchange for RGB input.
    always_comb begin
        rgb_w = rgb_raw;
        if (in_swap) begin
            rgb_w.r = rgb_raw.b;
            rgb_w.b = rgb_raw.r;
        end
    end

    // Choose between the held second packed pixel and the new word.
    always_comb begin
        if (pend_q) begin
            sel_yuv = 1'b1;
            sel_y   = pend_y;
            sel_cb  = pend_cb;
            sel_cr  = pend_cr;
        end else begin
            sel_yuv = is_yuv_in;
            sel_y   = y0_w;
            sel_cb  = cb_w;
            sel_cr  = cr_w;
        end
    end

    // Hold the second pixel of a packed word for one advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pend_y  <= '0;
            pend_cb <= '0;
            pend_cr <= '0;
        end else if (adv) begin
            if (pend_q) begin
                pend_q <= 1'b0;
            end else if (in_valid && is_pack) begin
                pend_q  <= 1'b1;
                pend_y  <= y1_w;
                pend_cb <= cb_w;
                pend_cr <= cr_w;
            end
        end
    end

    // Stage A register: offset-corrected samples or expanded RGB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_yuv   <= 1'b0;
            a_y     <= '0;
            a_u     <= '0;
            a_v     <= '0;
            a_rgb   <= '0;
        end else if (adv) begin
            a_valid <= pend_q || in_valid;
            a_yuv   <= sel_yuv;
            a_y     <= sub_off(sel_y,  luma_off);
            a_u     <= sub_off(sel_cb, chroma_off);
            a_v     <= sub_off(sel_cr, chroma_off);
            a_rgb   <= rgb_w;
        end
    end

endmodule

// File: rtl/ycc_mult.sv
// Stage B: forms the five weighted terms, one multiplier per coefficient.
// Assumes unsigned coefficients of COEF_W bits.
module ycc_mult
    import ycc_pkg::*;
#(
    parameter int COEF_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv,
    input  logic                      a_valid,
    input  logic                      a_yuv,
    input  logic signed [DIFF_W-1:0]  a_y,
    input  logic signed [DIFF_W-1:0]  a_u,
    input  logic signed [DIFF_W-1:0]  a_v,
    input  rgb_t                      a_rgb,
    input  logic [COEF_W-1:0]         coef [NPROD],
    output logic                      b_valid,
    output logic                      b_yuv,
    output rgb_t                      b_rgb,
    output logic signed [DIFF_W+COEF_W:0] b_prod [NPROD]
);

    localparam int PROD_W = DIFF_W + COEF_W + 1;

    for (genvar k = 0; k < NPROD; k++) begin : g_term
        localparam int SEL = operand_of(k);
        logic signed [DIFF_W-1:0] opnd;
        logic signed [PROD_W-1:0] prod_c;

        assign opnd   = (SEL == 0) ? a_y : (SEL == 1) ? a_u : a_v;
        assign prod_c = PROD_W'(opnd) * PROD_W'($signed({1'b0, coef[k]}));

        // Register weighted term k.
        always_ff @(posedge clk) begin
            if (!rst_n)   b_prod[k] <= '0;
            else if (adv) b_prod[k] <= prod_c;
        end
    end

    // Carry valid, path select and RGB bypass alongside the terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_yuv   <= 1'b0;
            b_rgb   <= '0;
        end else if (adv) begin
            b_valid <= a_valid;
            b_yuv   <= a_yuv;
            b_rgb   <= a_rgb;
        end
    end

endmodule

// File: rtl/ycc_clip.sv
// Divides a channel sum by 2**FRAC_BITS (floor) and clamps to 0..255.
// Purely combinational.
module ycc_clip
    import ycc_pkg::*;
#(
    parameter int SUM_W     = 24,
    parameter int FRAC_BITS = 10
) (
    input  logic signed [SUM_W-1:0] sum,
    output logic [PIX_W-1:0]        q
);

    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

    logic signed [SUM_W-1:0] shifted;

    assign shifted = sum >>> FRAC_BITS;

    // Saturate the shifted sum into the pixel range.
    always_comb begin
        if (shifted < 0)         q = '0;
        else if (shifted > MAXV) q = '1;
        else                     q = shifted[PIX_W-1:0];
    end

endmodule

// File: rtl/ycc_back.sv
// Stage C: sums the weighted terms per channel, clamps, and registers
// the output pixel. Bypassed RGB is registered unchanged.
module ycc_back
    import ycc_pkg::*;
#(
    parameter int COEF_W    = 12,
    parameter int FRAC_BITS = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv,
    input  logic                          b_valid,
    input  logic                          b_yuv,
    input  rgb_t                          b_rgb,
    input  logic signed [DIFF_W+COEF_W:0] b_prod [NPROD],
    output logic                          c_valid,
    output rgb_t                          c_rgb
);

    localparam int PROD_W = DIFF_W + COEF_W + 1;
    localparam int SUM_W  = PROD_W + 2;

    logic signed [SUM_W-1:0] sum [NCHAN];
    logic [PIX_W-1:0]        chan [NCHAN];
    rgb_t                    conv;

    assign sum[0] = SUM_W'(b_prod[0]) + SUM_W'(b_prod[1]);
    assign sum[1] = SUM_W'(b_prod[0]) - SUM_W'(b_prod[2]) - SUM_W'(b_prod[3]);
    assign sum[2] = SUM_W'(b_prod[0]) + SUM_W'(b_prod[4]);

    for (genvar c = 0; c < NCHAN; c++) begin : g_clip
        ycc_clip #(.SUM_W(SUM_W), .FRAC_BITS(FRAC_BITS)) u_clip (
            .sum (sum[c]),
            .q   (chan[c])
        );
    end

    assign conv = '{r: chan[0], g: chan[1], b: chan[2]};

    // Output register: converted or bypassed pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_valid <= 1'b0;
            c_rgb   <= '0;
        end else if (adv) begin
            c_valid <= b_valid;
            c_rgb   <= b_yuv ? conv : b_rgb;
        end
    end

endmodule

// File: rtl/ycc_rgb_conv.sv
// Top of the colour converter: three-register pipeline with a single
// advance enable, so back-pressure freezes every stage together.
module ycc_rgb_conv
    import ycc_pkg::*;
#(
    parameter int COEF_W    = 12,
    parameter int FRAC_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    input  logic [2:0]        in_fmt,
    input  logic [1:0]        in_order,
    input  logic              in_swap,
    input  logic [7:0]        luma_off,
    input  logic [7:0]        chroma_off,
    input  logic [COEF_W-1:0] coef_c0,
    input  logic [COEF_W-1:0] coef_c1,
    input  logic [COEF_W-1:0] coef_c2,
    input  logic [COEF_W-1:0] coef_c3,
    input  logic [COEF_W-1:0] coef_c4,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_r,
    output logic [7:0]        out_g,
    output logic [7:0]        out_b
);

    logic                          adv;
    logic                          a_valid, a_yuv, b_valid, b_yuv;
    logic signed [DIFF_W-1:0]      a_y, a_u, a_v;
    rgb_t                          a_rgb, b_rgb, c_rgb;
    logic [COEF_W-1:0]             coef [NPROD];
    logic signed [DIFF_W+COEF_W:0] b_prod [NPROD];

    assign coef[0] = coef_c0;
    assign coef[1] = coef_c1;
    assign coef[2] = coef_c2;
    assign coef[3] = coef_c3;
    assign coef[4] = coef_c4;

    assign adv   = !out_valid || out_ready;
    assign out_r = c_rgb.r;
    assign out_g = c_rgb.g;
    assign out_b = c_rgb.b;

    ycc_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_fmt     (in_fmt),
        .in_order   (in_order),
        .in_swap    (in_swap),
        .luma_off   (luma_off),
        .chroma_off (chroma_off),
        .in_ready   (in_ready),
        .a_valid    (a_valid),
        .a_yuv      (a_yuv),
        .a_y        (a_y),
        .a_u        (a_u),
        .a_v        (a_v),
        .a_rgb      (a_rgb)
    );

    ycc_mult #(.COEF_W(COEF_W)) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .a_valid (a_valid),
        .a_yuv   (a_yuv),
        .a_y     (a_y),
        .a_u     (a_u),
        .a_v     (a_v),
        .a_rgb   (a_rgb),
        .coef    (coef),
        .b_valid (b_valid),
        .b_yuv   (b_yuv),
        .b_rgb   (b_rgb),
        .b_prod  (b_prod)
    );

    ycc_back #(.COEF_W(COEF_W), .FRAC_BITS(FRAC_BITS)) u_back (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .b_valid (b_valid),
        .b_yuv   (b_yuv),
        .b_rgb   (b_rgb),
        .b_prod  (b_prod),
        .c_valid (out_valid),
        .c_rgb   (c_rgb)
    );

endmodule

// File: rtl/ycc_rgb_conv_chk.sv
// Protocol checks on the converter's ports, bound to every instance.
module ycc_rgb_conv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [2:0] in_fmt,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_r,
    input logic [7:0] out_g,
    input logic [7:0] out_b
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

    AST_PACKED_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_fmt == 3'd1) |=> !in_ready); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_r)
                                       && $stable(out_g) && $stable(out_b))); // R10

    AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R10

endmodule

bind ycc_rgb_conv ycc_rgb_conv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_fmt    (in_fmt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
);

// File: tb/ycc_rgb_conv_test.sv
`timescale 1ns/1ps
module ycc_rgb_conv_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [2:0]  in_fmt = '0;
    logic [1:0]  in_order = '0;
    logic        in_swap = 1'b0;
    logic [7:0]  luma_off = 8'd0;
    logic [7:0]  chroma_off = 8'd128;
    logic [11:0] coef_c0 = 12'h4A8, coef_c1 = 12'h662, coef_c2 = 12'h191;
    logic [11:0] coef_c3 = 12'h341, coef_c4 = 12'h811;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_r, out_g, out_b;

    always #10 clk = ~clk;   // 50 MHz

    ycc_rgb_conv uut (.*);

    int n_checks = 0, n_fail = 0;
    int exp_q[$];
    int cur_req = 6;
    int bp_mode = 0;
    int cyc = 0;
    bit last_fire = 0, chk_pair = 0, hold_chk = 0;
    logic [23:0] held;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %06h expected %06h", req, act, exp);
        end
    endtask

    function automatic int sat(input int s);
        int q;
        if (s < 0) return 0;
        q = s / 1024;
        return (q > 255) ? 255 : q;
    endfunction

    function automatic int conv(input int y, input int cb, input int cr);
        int yy, u, v;
        yy = y - int'(luma_off);
        u  = cb - int'(chroma_off);
        v  = cr - int'(chroma_off);
        return (sat(int'(coef_c0)*yy + int'(coef_c1)*v) << 16)
             | (sat(int'(coef_c0)*yy - int'(coef_c2)*u - int'(coef_c3)*v) << 8)
             |  sat(int'(coef_c0)*yy + int'(coef_c4)*u);
    endfunction

    function automatic int wid(input int v, input int bits);
        return (v << (8 - bits)) | (v >> (2*bits - 8));
    endfunction

    // Expected pixel(s) of the accepted word, pushed in output order.
    task automatic push_expected();
        int b0, b1, b2, b3, r, g, b, t;
        b0 = in_data[7:0]; b1 = in_data[15:8]; b2 = in_data[23:16]; b3 = in_data[31:24];
        case (in_fmt)
            3'd0: exp_q.push_back((cur_req << 24) | conv(b0, b1, b2));
            3'd1: begin
                case (in_order)
                    2'd0: begin exp_q.push_back((cur_req<<24)|conv(b0,b1,b3)); exp_q.push_back((cur_req<<24)|conv(b2,b1,b3)); end
                    2'd1: begin exp_q.push_back((cur_req<<24)|conv(b0,b3,b1)); exp_q.push_back((cur_req<<24)|conv(b2,b3,b1)); end
                    2'd2: begin exp_q.push_back((cur_req<<24)|conv(b1,b0,b2)); exp_q.push_back((cur_req<<24)|conv(b3,b0,b2)); end
                    default: begin exp_q.push_back((cur_req<<24)|conv(b1,b2,b0)); exp_q.push_back((cur_req<<24)|conv(b3,b2,b0)); end
                endcase
            end
            default: begin
                if (in_fmt == 3'd2) begin
                    r = wid((in_data >> 10) & 31, 5); g = wid((in_data >> 5) & 31, 5); b = wid(in_data & 31, 5);
                end else if (in_fmt == 3'd3) begin
                    r = wid((in_data >> 11) & 31, 5); g = wid((in_data >> 5) & 63, 6); b = wid(in_data & 31, 5);
                end else begin
                    r = b2; g = b1; b = b0;
                end
                if (in_swap) begin t = r; r = b; b = t; end
                exp_q.push_back((cur_req << 24) | (r << 16) | (g << 8) | b);
            end
        endcase
    endtask

    // Per-clock comparison against the reference queue.
    task automatic account();
        int e;
        string rq;
        last_fire = in_valid && in_ready;
        if (chk_pair) begin check("R5 second-pixel ready", int'(in_ready), 0); chk_pair = 0; end
        if (hold_chk) begin
            check("R10 stalled output held", {7'd0, out_valid, out_r, out_g, out_b}, {8'd1, held});
            hold_chk = 0;
        end
        if (out_valid && !out_ready) begin
            check("R10 ready during stall", int'(in_ready), 0);
            hold_chk = 1;
            held = {out_r, out_g, out_b};
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected pixel", {out_r, out_g, out_b}, -1);
            end else begin
                e = exp_q.pop_front();
                rq = $sformatf("R%0d", e >>> 24);
                check(rq, {8'd0, out_r, out_g, out_b}, e & 32'hFFFFFF);
            end
        end
        if (last_fire) begin
            push_expected();
            if (in_fmt == 3'd1) chk_pair = 1;
        end
    endtask

    task automatic tick();
        case (bp_mode)
            1: out_ready = (cyc % 3) != 0;
            2: out_ready = ((cyc * 7) % 5) < 2;
            default: out_ready = 1'b1;
        endcase
        #1;
        account();
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic send(input logic [31:0] d, input logic [2:0] f,
                        input logic [1:0] o, input logic s);
        in_valid = 1'b1; in_data = d; in_fmt = f; in_order = o; in_swap = s;
        do tick(); while (!last_fire);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin : watchdog
        #(20ns * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int seed, lat;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 out_valid", int'(out_valid), 0);
        #1 check("R1 in_ready", int'(in_ready), 1);
        idle(2);

        // R9: latency with an empty pipeline
        cur_req = 9;
        send(32'h00_80_80_80, 3'd0, 2'd0, 1'b0);
        lat = 0;
        for (int k = 1; k <= 6; k++) begin
            if (lat == 0 && out_valid) lat = k;
            tick();
        end
        check("R9 latency", lat, 3);

        // R6/R3: planar pixels with default settings
        cur_req = 6;
        send(32'h00_80_80_80, 3'd0, 2'd0, 1'b0);
        send(32'h00_40_C0_60, 3'd0, 2'd0, 1'b0);
        cur_req = 3;
        send(32'h00_5A_F0_29, 3'd0, 2'd0, 1'b0);
        // R4: saturation high and low
        cur_req = 4;
        send(32'h00_FF_80_FF, 3'd0, 2'd0, 1'b0);
        send(32'h00_00_00_00, 3'd0, 2'd0, 1'b0);
        send(32'h00_00_FF_FF, 3'd0, 2'd0, 1'b0);
        // R8: swap has no effect on luma/chroma input
        cur_req = 8;
        send(32'h00_30_A0_C8, 3'd0, 2'd0, 1'b1);
        idle(5);

        // R5: packed 4:2:2, every byte order, with and without stalls
        cur_req = 5;
        for (int m = 0; m < 2; m++) begin
            bp_mode = m;
            for (int o = 0; o < 4; o++) send(32'hE0_30_B0_50, 3'd1, 2'(o), 1'b0);
        end
        bp_mode = 0;
        idle(5);

        // R7: 15- and 16-bit RGB expansion
        cur_req = 7;
        send(32'h0000_7C1F, 3'd2, 2'd0, 1'b0);
        send(32'h0000_5295, 3'd2, 2'd0, 1'b1);
        send(32'h0000_F81F, 3'd3, 2'd0, 1'b0);
        send(32'h0000_07E0, 3'd3, 2'd0, 1'b1);
        send(32'h0000_A5C3, 3'd3, 2'd0, 1'b0);
        // R8: 24-bit pass-through, swap, codes above 4
        cur_req = 8;
        send(32'h00_12_34_56, 3'd4, 2'd0, 1'b0);
        send(32'h00_12_34_56, 3'd4, 2'd0, 1'b1);
        send(32'h00_AB_CD_EF, 3'd6, 2'd0, 1'b0);
        idle(5);

        // R2: programmed offsets and weights
        cur_req = 2;
        luma_off = 8'd16; chroma_off = 8'd100;
        coef_c0 = 12'h400; coef_c1 = 12'h200; coef_c2 = 12'h0FF; coef_c3 = 12'h123; coef_c4 = 12'hFFF;
        send(32'h00_10_64_64, 3'd0, 2'd0, 1'b0);
        send(32'h00_08_90_20, 3'd0, 2'd0, 1'b0);
        send(32'h70_22_9A_C4, 3'd1, 2'd2, 1'b0);
        idle(5);
        luma_off = 8'd0; chroma_off = 8'd128;
        coef_c0 = 12'h4A8; coef_c1 = 12'h662; coef_c2 = 12'h191; coef_c3 = 12'h341; coef_c4 = 12'h811;

        // R10: mixed formats under irregular back-pressure
        cur_req = 10;
        bp_mode = 2;
        seed = 17;
        for (int i = 0; i < 40; i++) begin
            seed = seed * 1103515245 + 12345;
            send(seed, 3'(i % 6), 2'(seed >>> 9), seed[20]);
        end
        bp_mode = 0;
        idle(10);
        check("R10 pixels outstanding", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule